// File: doc/BRIEF.md
# Register Rename Map

This block translates architectural (logical) register numbers into physical register numbers for an out-of-order core that has more physical registers than logical ones. It holds three pieces of state. The speculative map gives the current physical home of each logical register as seen by newly issued instructions. The committed map gives the same thing as seen by retired instructions only. A circular free list holds the physical registers that nothing currently owns.

When an instruction issues, its logical destination is given the physical register at the head of the free list. The previous mapping of that logical register is returned with it, so that the reorder buffer can carry it. Source operands are translated through the speculative map. When an instruction retires, its new mapping is written into the committed map, and the displaced physical register goes back onto the tail of the free list.

On a misprediction, the speculative map is overwritten with the committed map in one cycle. The free list is rebuilt as every physical register that the committed map does not own, in ascending order. This releases all physical registers that were handed out speculatively. Result data and the reorder buffer are outside this block.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, logical register i maps to physical register i. The free list then holds physical registers NUM_LOG to NUM_PHYS-1 and hands them out in ascending order.
- R2: While `ren_ready` is high and `ren_valid` is asserted, `ren_pdst` is the free-list head and `ren_pold` is the current speculative mapping of `ren_ldst`. From the next cycle on, lookups of `ren_ldst` return `ren_pdst`.
- R3: Each source lane k (bits k*3 up to k*3+2 of `src_lreg`, bits k*4 up to k*4+3 of `src_preg`) returns the speculative mapping combinationally. A rename of the same logical register in the same cycle does not affect the result, which is the mapping from before that rename.
- R4: `ren_ready` is low when the free list is empty or `flush` is high. While it is low, `ren_valid` changes neither the map nor the free list.
- R5: A commit pushes `cmt_pold` onto the free-list tail. It is handed out only after all physical registers that were already free.
- R6: A commit writes `cmt_pdst` into the committed-map entry of `cmt_ldst`.
- R7: One cycle after `flush`, every speculative mapping equals the committed map, including any commit given in the flush cycle.
- R8: On `flush`, the free list is rebuilt as all physical registers absent from the committed map, handed out in ascending order.
- R9: A rename and a commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_ldst | input | 3 | Logical destination to rename |
| ren_ready | output | 1 | A rename can be accepted this cycle |
| ren_pdst | output | 4 | Newly assigned physical register |
| ren_pold | output | 4 | Previous physical mapping of `ren_ldst` |
| src_lreg | input | 6 | Logical sources, 3 bits per lane |
| src_preg | output | 8 | Physical sources, 4 bits per lane |
| cmt_valid | input | 1 | Commit of the oldest renamed instruction |
| cmt_ldst | input | 3 | Logical destination of the committing instruction |
| cmt_pdst | input | 4 | Physical register it was given |
| cmt_pold | input | 4 | Physical register it displaced, to be freed |
| flush | input | 1 | Misprediction recovery |

## Verification
The bench first sweeps all logical registers through both source lanes after reset. It then renames every logical register with a source lane reading the same register, which separates the pre-rename mapping from the post-rename one and drains the free list to empty. Directed commits, a combined rename with commit, and a flush carrying a commit then show free-list ordering, recovery of the committed state and the ascending rebuild. A long pseudo-random run mixes renames, in-order commits and flushes against an arithmetic model of both maps and the free queue.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_NUM_LOG  = 8;
  localparam int RN_NUM_PHYS = 16;
  localparam int RN_NUM_SRC  = 2;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter  int N  = 8,
  parameter  int VW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [VW-1:0]   wr_val,
  input  logic            ld_en,
  input  logic [N*VW-1:0] ld_map,
  output logic [N*VW-1:0] map_o
);
  logic [VW-1:0] tbl_q [N];
  logic [VW-1:0] tbl_d [N];

  always_comb begin
    tbl_d = tbl_q;
    if (ld_en) begin
      for (int i = 0; i < N; i++) tbl_d[i] = ld_map[i*VW +: VW];
    end else if (wr_en) begin
      tbl_d[wr_idx] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl_q[i] <= VW'(i);
    end else if (wr_en || ld_en) begin
      tbl_q <= tbl_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign map_o[g*VW +: VW] = tbl_q[g];
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter  int NUM_PHYS = 16,
  parameter  int NUM_LOG  = 8,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pop,
  input  logic                push,
  input  logic [PW-1:0]       push_val,
  input  logic                rebuild,
  input  logic [NUM_PHYS-1:0] in_use,
  output logic [PW-1:0]       head_o,
  output logic                empty_o,
  output logic [CW-1:0]       count_o
);
  logic [PW-1:0] mem_q [NUM_PHYS];
  logic [PW-1:0] mem_d [NUM_PHYS];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mem_d  = mem_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (rebuild) begin
      cnt_d = '0;
      for (int i = 0; i < NUM_PHYS; i++) begin
        if (!in_use[i]) begin
          mem_d[cnt_d[PW-1:0]] = PW'(i);
          cnt_d = cnt_d + CW'(1);
        end
      end
      head_d = '0;
      tail_d = (cnt_d == CW'(NUM_PHYS)) ? '0 : cnt_d[PW-1:0];
    end else begin
      if (pop) head_d = wrap_inc(head_q);
      if (push) begin
        mem_d[tail_q] = push_val;
        tail_d = wrap_inc(tail_q);
      end
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign upd_en = rebuild || pop || push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PHYS; k++)
        mem_q[k] <= (k < NUM_PHYS - NUM_LOG) ? PW'(NUM_LOG + k) : '0;
      head_q <= '0;
      tail_q <= PW'((NUM_PHYS - NUM_LOG) % NUM_PHYS);
      cnt_q  <= CW'(NUM_PHYS - NUM_LOG);
    end else if (upd_en) begin
      mem_q  <= mem_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = mem_q[head_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  // R4: never take a register from an empty list
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  // R5: a freed register always finds a slot
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !rebuild) |-> (cnt_q != CW'(NUM_PHYS)));
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
  import rn_pkg::*;
#(
  parameter  int NUM_LOG  = RN_NUM_LOG,
  parameter  int NUM_PHYS = RN_NUM_PHYS,
  parameter  int NUM_SRC  = RN_NUM_SRC,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ren_valid,
  input  logic [LW-1:0]        ren_ldst,
  output logic                 ren_ready,
  output logic [PW-1:0]        ren_pdst,
  output logic [PW-1:0]        ren_pold,
  input  logic [NUM_SRC*LW-1:0] src_lreg,
  output logic [NUM_SRC*PW-1:0] src_preg,
  input  logic                 cmt_valid,
  input  logic [LW-1:0]        cmt_ldst,
  input  logic [PW-1:0]        cmt_pdst,
  input  logic [PW-1:0]        cmt_pold,
  input  logic                 flush
);
  logic [NUM_LOG*PW-1:0] smap_flat, cmap_flat, cmap_nx;
  logic [NUM_PHYS-1:0]   used_mask;
  logic [PW-1:0]         fl_head;
  logic                  fl_empty;
  logic [CW-1:0]         fl_count;
  logic                  ren_fire;

  assign ren_ready = !fl_empty && !flush;
  assign ren_fire  = ren_valid && ren_ready;
  assign ren_pdst  = fl_head;
  assign ren_pold  = smap_flat[int'(ren_ldst)*PW +: PW];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_preg[g*PW +: PW] = smap_flat[int'(src_lreg[g*LW +: LW])*PW +: PW];
  end

  // committed map as it stands after this cycle's commit
  always_comb begin
    cmap_nx = cmap_flat;
    if (cmt_valid) cmap_nx[int'(cmt_ldst)*PW +: PW] = cmt_pdst;
  end

  always_comb begin
    used_mask = '0;
    for (int l = 0; l < NUM_LOG; l++) used_mask[cmap_nx[l*PW +: PW]] = 1'b1;
  end

  rn_map_table #(.N(NUM_LOG), .VW(PW)) u_spec_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ren_fire), .wr_idx(ren_ldst), .wr_val(fl_head),
    .ld_en(flush), .ld_map(cmap_nx), .map_o(smap_flat)
  );

  rn_map_table #(.N(NUM_LOG), .VW(PW)) u_cmt_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmt_valid), .wr_idx(cmt_ldst), .wr_val(cmt_pdst),
    .ld_en(1'b0), .ld_map(cmap_flat), .map_o(cmap_flat)
  );

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(ren_fire), .push(cmt_valid && !flush), .push_val(cmt_pold),
    .rebuild(flush), .in_use(used_mask),
    .head_o(fl_head), .empty_o(fl_empty), .count_o(fl_count)
  );

  // checker logic: is the register about to be handed out already mapped?
  logic head_mapped;
  always_comb begin
    head_mapped = 1'b0;
    for (int l = 0; l < NUM_LOG; l++)
      if (smap_flat[l*PW +: PW] == fl_head) head_mapped = 1'b1;
  end

  // R2: a fresh destination is never one the speculative map already holds
  p_fresh_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |-> !head_mapped);
  // R7: recovery makes both maps identical
  p_flush_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (smap_flat == cmap_flat));
  // R8: rebuild leaves exactly the unowned registers free
  p_rebuild_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fl_count == CW'(NUM_PHYS - NUM_LOG)));
endmodule

// File: tb/rn_rename_map_tb.sv
module rn_rename_map_tb;
  localparam int PERIOD = 10;
  localparam int NL = 8;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, ren_ready, cmt_valid, flush;
  logic [2:0] ren_ldst, cmt_ldst;
  logic [3:0] ren_pdst, ren_pold, cmt_pdst, cmt_pold;
  logic [5:0] src_lreg;
  logic [7:0] src_preg;

  always #(PERIOD/2) clk = ~clk;

  rn_rename_map u_dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ldst(ren_ldst), .ren_ready(ren_ready),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .src_lreg(src_lreg), .src_preg(src_preg),
    .cmt_valid(cmt_valid), .cmt_ldst(cmt_ldst), .cmt_pdst(cmt_pdst),
    .cmt_pold(cmt_pold), .flush(flush)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int m_s[NL], m_c[NL];
  int fq[NP]; int fqn;
  int rl[NP], rp[NP], ro[NP]; int rn;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit rv, input int l, input bit cv_in, input bit fl,
                      input int s0, input int s1, input string ptag, input string stag);
    bit cv; bit rdy; int pd; int owner;
    @(negedge clk);
    cv = cv_in && (rn > 0);
    ren_valid = rv; ren_ldst = 3'(l); flush = fl;
    src_lreg = {3'(s1), 3'(s0)};
    cmt_valid = cv;
    cmt_ldst = cv ? 3'(rl[0]) : '0;
    cmt_pdst = cv ? 4'(rp[0]) : '0;
    cmt_pold = cv ? 4'(ro[0]) : '0;
    #1;
    rdy = (fqn > 0) && !fl;
    chk(int'(ren_ready), int'(rdy), "R4");
    if (rdy) chk(int'(ren_pdst), fq[0], ptag);
    chk(int'(ren_pold), m_s[l], "R2");
    chk(int'(src_preg[3:0]), m_s[s0], stag);
    chk(int'(src_preg[7:4]), m_s[s1], stag);
    @(posedge clk);
    if (cv) begin
      m_c[rl[0]] = rp[0];
      owner = ro[0];
      for (int i = 0; i < NP - 1; i++) begin rl[i] = rl[i+1]; rp[i] = rp[i+1]; ro[i] = ro[i+1]; end
      rn--;
    end
    if (fl) begin
      for (int i = 0; i < NL; i++) m_s[i] = m_c[i];
      fqn = 0;
      for (int p = 0; p < NP; p++) begin
        bit own = 0;
        for (int i = 0; i < NL; i++) if (m_c[i] == p) own = 1;
        if (!own) begin fq[fqn] = p; fqn++; end
      end
      rn = 0;
    end else begin
      if (rv && rdy) begin
        pd = fq[0];
        for (int i = 0; i < NP - 1; i++) fq[i] = fq[i+1];
        fqn--;
        rl[rn] = l; rp[rn] = pd; ro[rn] = m_s[l]; rn++;
        m_s[l] = pd;
      end
      if (cv) begin fq[fqn] = owner; fqn++; end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ren_valid = 0; ren_ldst = 0; src_lreg = 0; flush = 0;
    cmt_valid = 0; cmt_ldst = 0; cmt_pdst = 0; cmt_pold = 0;
    for (int i = 0; i < NL; i++) begin m_s[i] = i; m_c[i] = i; end
    for (int i = 0; i < NP - NL; i++) fq[i] = NL + i;
    fqn = NP - NL; rn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity map after reset on both lanes
    for (int i = 0; i < NL; i++) step(0, i, 0, 0, i, NL - 1 - i, "R1", "R1");
    // R1/R3: rename every register, lane 0 reads the same register
    for (int i = 0; i < NL; i++) step(1, i, 0, 0, i, (i + 1) % NL, "R1", "R3");
    // R4: list empty, request must be ignored
    step(1, 3, 0, 0, 3, 4, "R4", "R4");
    step(0, 3, 0, 0, 3, 4, "R4", "R4");
    // R5: freed register comes back
    step(0, 0, 1, 0, 0, 1, "R5", "R3");
    step(1, 5, 0, 0, 5, 0, "R5", "R3");
    // R9: rename and commit together
    step(0, 0, 1, 0, 1, 2, "R9", "R3");
    step(1, 6, 1, 0, 6, 1, "R9", "R9");
    step(1, 7, 0, 0, 7, 6, "R9", "R9");
    // R7/R6: flush carrying a commit
    step(1, 2, 1, 1, 2, 6, "R7", "R7");
    for (int i = 0; i < NL; i++) step(0, i, 0, 0, i, (i + 3) % NL, "R6", "R6");
    // R8: rebuilt list in ascending order
    for (int i = 0; i < NL + 1; i++) step(1, i % NL, 0, 0, i % NL, 0, "R8", "R3");

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, NL - 1),
           $urandom_range(0, 1) == 1, $urandom_range(0, 31) == 0,
           $urandom_range(0, NL - 1), $urandom_range(0, NL - 1), "R2", "R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule